// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block is the branch target table that sits beside an instruction fetch stage. Every cycle the fetch stage presents its current fetch address. In the same cycle, with no clock edge in the path, the block answers with three things: whether the address is a known branch, whether that branch is expected to be taken, and the address to fetch next. The next address is the stored target when the branch is predicted taken. Otherwise it is the sequential word after the fetch address.

When a branch resolves further down the pipe, the resolving stage drives an update with the branch address, the real outcome and the real target. The block keeps one direct-mapped entry per index. Each entry holds a valid bit, an address tag, a target address and a two-bit saturating history counter. A branch gets an entry only when it is first seen taken, and the new entry starts out biased towards not taken. From then on, every resolution of that branch moves its counter one step. A global enable bit lets control software switch prediction off. While it is off, the table is frozen and every fetch is told to go sequential.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous active-low reset invalidates every entry. After reset, every lookup reports a miss.
- R2: A lookup hits only when the enable is high and the entry at index fetch_addr[8:2] is valid. The stored tag must also equal fetch_addr[31:9].
- R3: The history counter uses these codes: 2'b11 strongly taken, 2'b10 weakly taken, 2'b01 weakly not taken and 2'b00 strongly not taken. pred_taken is high exactly when the lookup hits and the counter's upper bit is 1. In that case pred_target is the stored target; otherwise pred_target is fetch_addr + 4.
- R4: An update that misses the table and resolves taken writes the slot at its index. It stores a valid bit, the new tag, upd_target and history 2'b00, and it overwrites any other branch that held that slot.
- R5: An update that misses the table and resolves not taken leaves the whole table unchanged.
- R6: An update that hits the table increments the history counter when taken and decrements it when not taken. The counter saturates at 2'b11 and at 2'b00.
- R7: A taken update that hits replaces the stored target with upd_target. A not-taken update that hits keeps the stored target.
- R8: While enable is low, hit and pred_taken are low, pred_target is fetch_addr + 4 and updates are ignored. Raising enable again shows the table exactly as it was.
- R9: Updates take effect at the clock edge. A lookup in the same cycle as an update to the same index sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global predictor enable from control software |
| fetch_addr | input | 32 | Address being fetched this cycle |
| hit | output | 1 | fetch_addr matches a valid entry |
| pred_taken | output | 1 | Branch predicted taken |
| pred_target | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_addr | input | 32 | Address of the resolving branch |
| upd_taken | input | 1 | Actual outcome of the resolving branch |
| upd_target | input | 32 | Actual target of the resolving branch |

## Verification
Some behaviours are checked by assertions on every cycle. A taken prediction always comes with a hit, and a disabled table never hits. Any cycle that is not predicted taken gets the sequential address. The counter never wraps past either end, and a cycle with no write leaves the valid bits alone. Other behaviours are shown only by the bench's scenarios, each compared against a behavioural model on every clock. These are allocation in the strongly-not-taken state, eviction of an aliasing branch, target refresh on a taken hit, the freeze while disabled and the old-contents result when a lookup and an update meet at one index.

// File: rtl/btbp_pkg.sv
// Package: shared constants and the history counter encoding for the
// branch target buffer predictor.
// Assumes: history is a two-bit saturating counter whose upper bit is the
// taken/not-taken prediction.
package btbp_pkg;

    localparam int HIST_W = 2;

    typedef enum logic [HIST_W-1:0] {
        HIST_SNT = 2'b00,
        HIST_WNT = 2'b01,
        HIST_WT  = 2'b10,
        HIST_ST  = 2'b11
    } hist_e;

    // Initial history of a freshly allocated entry.
    localparam hist_e HIST_ALLOC = HIST_SNT;

endpackage

// File: rtl/btbp_addr_split.sv
// Module: btbp_addr_split
// Splits a byte address into the table index and the tag for a
// direct-mapped table.
// Assumes: instructions are word aligned, so the low OFS_W bits carry no
// information and are dropped.
module btbp_addr_split #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7,
    parameter int OFS_W  = 2
) (
    input  logic [ADDR_W-1:0]             addr,
    output logic [IDX_W-1:0]              idx,
    output logic [ADDR_W-IDX_W-OFS_W-1:0] tag
);
    localparam int TAG_LSB = IDX_W + OFS_W;

    // Slice the address into the index and tag fields.
    always_comb begin
        idx = addr[TAG_LSB-1:OFS_W];
        tag = addr[ADDR_W-1:TAG_LSB];
    end

endmodule

// File: rtl/btbp_hist_ctr.sv
// Module: btbp_hist_ctr
// Computes the next value of a saturating history counter from its current
// value and the resolved outcome.
// Assumes: the counter has HIST_W bits. All ones is the strongest taken
// state and zero is the strongest not-taken state.
module btbp_hist_ctr
    import btbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] cur,
    input  logic              taken,
    output logic [HIST_W-1:0] nxt
);
    localparam logic [HIST_W-1:0] CTR_MAX = '1;
    localparam logic [HIST_W-1:0] CTR_MIN = '0;

    // Step the counter towards the outcome and stop at either end.
    always_comb begin
        nxt = cur;
        if (taken) begin
            if (cur != CTR_MAX) nxt = cur + 1'b1;
        end else begin
            if (cur != CTR_MIN) nxt = cur - 1'b1;
        end
    end

    // R6: the counter never wraps at the top.
    a_r6_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && cur == CTR_MAX) |-> nxt == CTR_MAX);

    // R6: the counter never wraps at the bottom.
    a_r6_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!taken && cur == CTR_MIN) |-> nxt == CTR_MIN);

endmodule

// File: rtl/btbp_entry_array.sv
// Module: btbp_entry_array
// Storage for the predictor entries. It has two combinational read ports
// (fetch lookup and update lookup) and one synchronous write port. Reset
// clears only the valid bits.
// Assumes: at most one entry is written per cycle. A read at the index
// being written returns the old contents.
module btbp_entry_array
    import btbp_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int TAG_W = 23,
    parameter int TGT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    // fetch-side read port
    input  logic [IDX_W-1:0]  ra_idx,
    output logic              ra_valid,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [TGT_W-1:0]  ra_tgt,
    output logic [HIST_W-1:0] ra_hist,
    // update-side read port
    input  logic [IDX_W-1:0]  rb_idx,
    output logic              rb_valid,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [TGT_W-1:0]  rb_tgt,
    output logic [HIST_W-1:0] rb_hist,
    // write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [TGT_W-1:0]  wr_tgt,
    input  logic [HIST_W-1:0] wr_hist
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [TGT_W-1:0]   tgt_q  [ENTRIES];
    logic [HIST_W-1:0]  hist_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        // Valid bit: cleared by reset, set by any write to this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)   valid_q[e] <= 1'b0;
            else if (sel) valid_q[e] <= 1'b1;
        end

        // Payload: tag, target and history, loaded on a write.
        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[e]  <= wr_tag;
                tgt_q[e]  <= wr_tgt;
                hist_q[e] <= wr_hist;
            end
        end
    end

    // Fetch-side read: a plain mux with no bypass of the write port.
    always_comb begin
        ra_valid = valid_q[ra_idx];
        ra_tag   = tag_q[ra_idx];
        ra_tgt   = tgt_q[ra_idx];
        ra_hist  = hist_q[ra_idx];
    end

    // Update-side read: used to decide between a hit update and an allocation.
    always_comb begin
        rb_valid = valid_q[rb_idx];
        rb_tag   = tag_q[rb_idx];
        rb_tgt   = tgt_q[rb_idx];
        rb_hist  = hist_q[rb_idx];
    end

    // R5: a cycle with no write leaves every valid bit unchanged.
    a_r5_idle_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_q));

    // R4: a written entry reads back as valid on the following cycle.
    a_r4_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ra_idx == wr_idx) |=> (ra_valid || ra_idx != $past(wr_idx)));

endmodule

// File: rtl/btb_predictor.sv
// Module: btb_predictor
// Direct-mapped branch target buffer. The lookup is combinational from the
// fetch address. A resolved branch updates its entry's history when it hits
// and allocates a fresh entry, strongly not taken, when it misses but was
// taken.
// Assumes: word-aligned instructions, and at most one resolution per cycle.
// The enable freezes the table and forces sequential prediction.
module btb_predictor
    import btbp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
    localparam logic [ADDR_W-1:0] SEQ_STEP = ADDR_W'(1) << OFS_W;

    logic [IDX_W-1:0]  f_idx, u_idx;
    logic [TAG_W-1:0]  f_tag, u_tag;
    logic              ra_valid, rb_valid;
    logic [TAG_W-1:0]  ra_tag, rb_tag;
    logic [ADDR_W-1:0] ra_tgt, rb_tgt;
    logic [HIST_W-1:0] ra_hist, rb_hist;
    logic [HIST_W-1:0] hist_nxt;
    logic              u_hit, u_act;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_tgt;
    logic [HIST_W-1:0] wr_hist;

    btbp_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) i_split_fetch (
        .addr (fetch_addr),
        .idx  (f_idx),
        .tag  (f_tag)
    );

    btbp_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) i_split_upd (
        .addr (upd_addr),
        .idx  (u_idx),
        .tag  (u_tag)
    );

    btbp_entry_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(ADDR_W)) i_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (f_idx),
        .ra_valid (ra_valid),
        .ra_tag   (ra_tag),
        .ra_tgt   (ra_tgt),
        .ra_hist  (ra_hist),
        .rb_idx   (u_idx),
        .rb_valid (rb_valid),
        .rb_tag   (rb_tag),
        .rb_tgt   (rb_tgt),
        .rb_hist  (rb_hist),
        .wr_en    (wr_en),
        .wr_idx   (u_idx),
        .wr_tag   (u_tag),
        .wr_tgt   (wr_tgt),
        .wr_hist  (wr_hist)
    );

    btbp_hist_ctr i_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (rb_hist),
        .taken (upd_taken),
        .nxt   (hist_nxt)
    );

    // Lookup: tag compare, then choose between the stored and sequential target.
    always_comb begin
        hit         = enable && ra_valid && (ra_tag == f_tag);
        pred_taken  = hit && ra_hist[HIST_W-1];
        pred_target = pred_taken ? ra_tgt : fetch_addr + SEQ_STEP;
    end

    // Update decision: a hit steps the counter, a taken miss allocates.
    always_comb begin
        u_act   = enable && upd_valid;
        u_hit   = rb_valid && (rb_tag == u_tag);
        wr_en   = u_act && (u_hit || upd_taken);
        wr_hist = u_hit ? hist_nxt : HIST_ALLOC;
        wr_tgt  = upd_taken ? upd_target : rb_tgt;
    end

    // R3: a taken prediction is only ever made for a hit.
    a_r3_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> hit);

    // R3: without a taken prediction, fetch continues sequentially.
    a_r3_seq_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_target == fetch_addr + SEQ_STEP);

    // R8: a disabled table never reports a hit or a taken prediction.
    a_r8_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!hit && !pred_taken));

    // R8: a disabled table is never written.
    a_r8_off_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !wr_en);

endmodule

// File: tb/test_btb_predictor.sv
module test_btb_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int N_ENT = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        hit, pred_taken;
    logic [31:0] pred_target;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int vectors = 0;
    int miscompares = 0;

    // behavioural model of the table
    bit          m_valid [N_ENT];
    int unsigned m_tag   [N_ENT];
    logic [31:0] m_tgt   [N_ENT];
    int          m_hist  [N_ENT];

    always #(CLK_PERIOD/2) clk = ~clk;

    btb_predictor i_btb_predictor (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .fetch_addr  (fetch_addr),
        .hit         (hit),
        .pred_taken  (pred_taken),
        .pred_target (pred_target),
        .upd_valid   (upd_valid),
        .upd_addr    (upd_addr),
        .upd_taken   (upd_taken),
        .upd_target  (upd_target)
    );

    function automatic int slot_of(logic [31:0] a);
        return int'((a / 4) % N_ENT);
    endfunction

    function automatic int unsigned tag_of(logic [31:0] a);
        return int'(a / 512);
    endfunction

    // model state change at a clock edge
    function automatic void model_edge();
        int s;
        bit h;
        if (!rst_n) begin
            foreach (m_valid[k]) m_valid[k] = 1'b0;
        end else if (enable && upd_valid) begin
            s = slot_of(upd_addr);
            h = m_valid[s] && (m_tag[s] == tag_of(upd_addr));
            if (h) begin
                if (upd_taken) begin
                    m_hist[s] = (m_hist[s] < 3) ? m_hist[s] + 1 : 3;
                    m_tgt[s] = upd_target;
                end else begin
                    m_hist[s] = (m_hist[s] > 0) ? m_hist[s] - 1 : 0;
                end
            end else if (upd_taken) begin
                m_valid[s] = 1'b1;
                m_tag[s] = tag_of(upd_addr);
                m_tgt[s] = upd_target;
                m_hist[s] = 0;
            end
        end
    endfunction

    // compare the combinational outputs, then advance one clock
    task automatic step(string req);
        logic        e_hit, e_tk;
        logic [31:0] e_tgt;
        int          s;
        #1;
        if (rst_n) begin
            s = slot_of(fetch_addr);
            e_hit = enable && m_valid[s] && (m_tag[s] == tag_of(fetch_addr));
            e_tk  = e_hit && (m_hist[s] >= 2);
            e_tgt = e_tk ? m_tgt[s] : fetch_addr + 32'd4;
            vectors++;
            if (hit !== e_hit) begin
                miscompares++;
                $display("FAIL %s hit addr=%h actual=%b expected=%b", req, fetch_addr, hit, e_hit);
            end
            if (pred_taken !== e_tk) begin
                miscompares++;
                $display("FAIL %s pred_taken addr=%h actual=%b expected=%b", req, fetch_addr, pred_taken, e_tk);
            end
            if (pred_target !== e_tgt) begin
                miscompares++;
                $display("FAIL %s pred_target addr=%h actual=%h expected=%h", req, fetch_addr, pred_target, e_tgt);
            end
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic look(logic [31:0] a, string req);
        upd_valid = 1'b0;
        fetch_addr = a;
        step(req);
    endtask

    task automatic resolve(logic [31:0] a, bit tk, logic [31:0] t, logic [31:0] f, string req);
        upd_valid = 1'b1;
        upd_addr = a;
        upd_taken = tk;
        upd_target = t;
        fetch_addr = f;
        step(req);
        upd_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] A, B, C, D;
        A = 32'h0000_1040;
        B = 32'h0000_2080;
        C = A + 32'h0000_0200;   // same slot as A, different tag
        D = 32'h0000_30C0;
        @(negedge clk);
        rst_n = 1'b0;
        enable = 1'b1;
        repeat (3) step("R1");
        rst_n = 1'b1;

        // R1: empty table after reset
        look(A, "R1");
        look(B, "R1");

        // R4: first taken resolution allocates, strongly not taken
        resolve(A, 1'b1, 32'h0000_8000, A, "R4");
        look(A, "R4");

        // R6 and R3: counter climbs to taken, then saturates
        resolve(A, 1'b1, 32'h0000_8000, A, "R6");
        look(A, "R6");
        resolve(A, 1'b1, 32'h0000_8000, A, "R3");
        look(A, "R3");
        resolve(A, 1'b1, 32'h0000_8000, A, "R6");
        resolve(A, 1'b1, 32'h0000_8000, A, "R6");
        look(A, "R6");

        // R7: taken hit refreshes the target; not-taken hit keeps it
        resolve(A, 1'b1, 32'h0000_9000, A, "R7");
        look(A, "R7");
        resolve(A, 1'b0, 32'h0000_ABC0, A, "R7");
        look(A, "R7");

        // R6: walk down to strongly not taken and saturate there
        for (int k = 0; k < 5; k++) resolve(A, 1'b0, 32'h0, A, "R6");
        look(A, "R6");

        // R5: not-taken miss creates nothing
        resolve(B, 1'b0, 32'h0000_7000, B, "R5");
        look(B, "R5");

        // R4: alias evicts A
        resolve(C, 1'b1, 32'h0000_4400, C, "R4");
        look(A, "R4");
        look(C, "R4");

        // R9: lookup during update of same slot sees old contents
        resolve(C, 1'b1, 32'h0000_4400, C, "R9");
        resolve(C, 1'b1, 32'h0000_5500, C, "R9");
        resolve(A, 1'b1, 32'h0000_6600, C, "R9");
        look(C, "R9");
        look(A, "R9");

        // R8: disabled table misses and ignores updates
        resolve(D, 1'b1, 32'h0000_0100, D, "R8");
        resolve(D, 1'b1, 32'h0000_0100, D, "R8");
        resolve(D, 1'b1, 32'h0000_0100, D, "R8");
        look(D, "R8");
        enable = 1'b0;
        look(D, "R8");
        resolve(D, 1'b0, 32'h0, D, "R8");
        resolve(A, 1'b1, 32'h0000_0200, A, "R8");
        look(D, "R8");
        enable = 1'b1;
        look(D, "R8");
        look(A, "R8");

        // R2: many slots and tags, pseudo-random mix
        for (int k = 0; k < 600; k++) begin
            logic [31:0] a;
            a = {20'h0, 3'(k * 7 % 5), 7'(k * 37 % N_ENT), 2'b00};
            if (k % 3 == 0) look(a, "R2");
            else resolve(a, (k % 4) != 1, a + 32'h100, {20'h0, 3'(k % 5), 7'(k * 11 % N_ENT), 2'b00}, "R2");
        end

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        step("R1");
        rst_n = 1'b1;
        look(D, "R1");
        look(C, "R1");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule